// File: doc/BRIEF.md
# Event Timestamp and Timed-Trigger Unit

This block keeps a free-running local time counter and uses it for two jobs. It stamps selected events with the time at which they occur: a fault report, the arrival of a time tick from the serial link, and the start of a video packet. The stamps go into a short queue that a downstream reader drains. The same counter also drives a deferred-commit mechanism. A configuration word is written into a staging register, a trigger time is loaded, and the staged word moves to the live parameter output only in the cycle the local time equals that trigger time.

The time base advances once per cycle in which the advance enable is high. A link tick can overwrite it with a sync value supplied by the user, so the device time can be brought into line with the user's time. The event that marks tick reception is stamped with the local time, and this lets software measure the offset between the two time bases.

Top module: `evt_time_stamper`

## Requirements
- R1: After a synchronous reset the time counter reads 0, no trigger is pending, the apply strobe is low, the parameter output is 0, the event queue is empty and the overflow flag is clear.
- R2: In a cycle with `time_adv` high and `sync_pulse` low, the counter rises by one at the next edge, and it wraps from 0xFFFFFFFF to 0 with no indication. With both low, it holds its value.
- R3: When `sync_pulse` is high, the counter takes `sync_value` at the next edge, whatever the state of `time_adv`.
- R4: An event strobe that is high in a cycle queues one entry. The entry holds the counter value of that cycle and a tag: fault = 0, tick received = 1, packet start = 2.
- R5: Strobes that arrive in the same cycle are queued in the order fault, tick, packet. All of them carry the same time.
- R6: The queue holds 4 entries. `ts_valid` is high while the queue is not empty, `ts_tag`/`ts_time` show the oldest entry, and `ts_pop` with `ts_valid` removes that entry. Room is counted before the pop of the same cycle. A strobe that finds no room is dropped, the entries already held are kept, and the sticky `ts_overflow` flag is set.
- R7: A write with `cfg_sel` = 0 loads the staging register and does not change `param_out`. `param_out` changes only in a cycle with `apply_stb` high.
- R8: A write with `cfg_sel` = 1 loads the trigger time and sets `trig_pending` at the next edge.
- R9: While a trigger is pending and the counter equals the trigger time, the next edge raises `apply_stb` for exactly one cycle, copies the staged word to `param_out` and clears `trig_pending`.
- R10: The trigger test is equality only. A pending trigger whose time has already passed does not fire until the counter reaches that value again, either by wrapping or through a sync load.
- R11: Writing a trigger time arms the unit again, including after a fire. A trigger write in the matching cycle replaces the old time, and that cycle does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_adv | input | 1 | Advance enable for the time counter |
| sync_pulse | input | 1 | Link tick: load the counter with `sync_value` |
| sync_value | input | 32 | Time value loaded on a link tick |
| evt_error | input | 1 | Fault event strobe |
| evt_tick_rx | input | 1 | Tick-received event strobe |
| evt_pkt_start | input | 1 | Video packet start strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 staging register, 1 trigger time |
| cfg_wdata | input | 32 | Configuration write data |
| ts_pop | input | 1 | Remove the oldest queued stamp |
| ts_valid | output | 1 | Queue holds at least one stamp |
| ts_tag | output | 2 | Tag of the oldest stamp |
| ts_time | output | 32 | Time of the oldest stamp |
| ts_overflow | output | 1 | Sticky flag: a stamp was dropped |
| now_time | output | 32 | Current local time |
| trig_pending | output | 1 | Trigger armed and not yet fired |
| apply_stb | output | 1 | One-cycle commit strobe |
| param_out | output | 32 | Committed parameter word |

## Verification
The properties place no limits on the inputs. They hold for any mix of strobes, writes and sync loads, including pops of an empty queue. They do depend on the queue depth being a power of two, so that the pointers wrap on their own. The random phase puts each trigger time a short distance ahead of the modelled current time, so triggers actually fire. It keeps sync loads rare, which lets most triggers be reached by counting. Directed sequences cover the cases random stimulus is unlikely to hit: the wrap edge, a trigger already in the past, a rewrite in the matching cycle, and queue overflow.

// File: rtl/evt_ts_pkg.sv
// Shared definitions for the event timestamp unit.
// The event tag codes double as the queue priority: lower code is queued first.
package evt_ts_pkg;

    typedef enum logic [1:0] {
        EV_ERR  = 2'd0,
        EV_TICK = 2'd1,
        EV_PKT  = 2'd2
    } ev_tag_e;

    localparam int EV_COUNT = 3;
    localparam int EV_TAG_W = 2;

endpackage

// File: rtl/ts_time_base.sv
// Local time counter.
// Advances by one in cycles with adv high and wraps silently at the top.
// A sync load takes precedence over the advance.
// Assumes adv and sync_ld are synchronous to clk.
module ts_time_base #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          sync_ld,
    input  logic [TW-1:0] sync_val,
    output logic [TW-1:0] now
);

    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt_q;

    // Counter register: reset, sync load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sync_ld) begin
            cnt_q <= sync_val;
        end else if (adv) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign now = cnt_q;

endmodule

// File: rtl/ts_event_queue.sv
// Timestamp queue with several prioritised writers.
// Each request bit i is one event source, and bit 0 has the highest priority.
// All requests of a cycle are written in index order, each with the same stamp.
// Room is the free space at the start of the cycle: a pop in the same cycle
// does not make room for that cycle's writes.
// Requests that find no room are dropped and set a sticky overflow flag.
// Assumes DEPTH is a power of two.
module ts_event_queue #(
    parameter int TW    = 32,
    parameter int DEPTH = 4,
    parameter int NSRC  = 3,
    parameter int TAGW  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_req,
    input  logic [TW-1:0]   stamp,
    input  logic            pop,
    output logic            head_valid,
    output logic [TAGW-1:0] head_tag,
    output logic [TW-1:0]   head_time,
    output logic            ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam int EW = TAGW + TW;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [EW-1:0]   mem [DEPTH];
    logic [AW-1:0]   rd_ptr, wr_ptr;
    logic [CW-1:0]   count;
    logic [CW-1:0]   room;
    logic [CW-1:0]   n_acc;
    logic [NSRC-1:0] wen;
    logic [AW-1:0]   wslot [NSRC];
    logic            drop;
    logic            pop_ok;

    // Slot allocation: hand out free slots to requesters in priority order.
    always_comb begin
        room  = FULL_CNT - count;
        n_acc = '0;
        drop  = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            wen[i]   = 1'b0;
            wslot[i] = wr_ptr + n_acc[AW-1:0];
            if (ev_req[i]) begin
                if (n_acc < room) begin
                    wen[i] = 1'b1;
                    n_acc  = n_acc + CW'(1);
                end else begin
                    drop = 1'b1;
                end
            end
        end
    end

    assign pop_ok = pop && (count != '0);

    // Storage write: tagged stamps into the allocated slots.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSRC; i++) begin
            if (wen[i]) begin
                mem[wslot[i]] <= {TAGW'(i), stamp};
            end
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            rd_ptr <= rd_ptr + AW'(pop_ok);
            wr_ptr <= wr_ptr + n_acc[AW-1:0];
            count  <= count + n_acc - CW'(pop_ok);
        end
    end

    // Sticky overflow flag: set on any dropped request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (drop) begin
            ovf <= 1'b1;
        end
    end

    assign head_valid = (count != '0);
    assign head_tag   = mem[rd_ptr][EW-1:TW];
    assign head_time  = mem[rd_ptr][TW-1:0];

endmodule

// File: rtl/ts_trigger_stage.sv
// Deferred commit of a staged parameter word.
// The staged word is copied to the live output in the cycle after the local
// time equals the armed trigger time. The strobe lasts one cycle and disarms.
// A trigger write re-arms, and in a matching cycle it wins over the fire.
// The test is equality only, so a trigger time already passed waits for the
// counter to come back round.
module ts_trigger_stage #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stage,
    input  logic          wr_trig,
    input  logic [TW-1:0] wdata,
    input  logic [TW-1:0] now,
    output logic          pending,
    output logic          apply,
    output logic [TW-1:0] param
);

    logic [TW-1:0] trig_q;
    logic [TW-1:0] stage_q;
    logic          armed_q;
    logic          hit;

    assign hit = armed_q && (now == trig_q) && !wr_trig;

    // Staging and trigger-time registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q  <= '0;
            stage_q <= '0;
        end else begin
            if (wr_trig)  trig_q  <= wdata;
            if (wr_stage) stage_q <= wdata;
        end
    end

    // Arm flag: set by a trigger write, cleared by a fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_trig) begin
            armed_q <= 1'b1;
        end else if (hit) begin
            armed_q <= 1'b0;
        end
    end

    // Commit: one-cycle strobe, with the live word loaded in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apply <= 1'b0;
            param <= '0;
        end else begin
            apply <= hit;
            if (hit) param <= stage_q;
        end
    end

    assign pending = armed_q;

endmodule

// File: rtl/evt_time_stamper.sv
// Event timestamp and timed-trigger unit, top level.
// Wires the time base, the prioritised stamp queue and the trigger stage.
// Event strobes map to queue priorities via the package tag codes.
// Assumes every input is synchronous to clk.
module evt_time_stamper #(
    parameter int TW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          time_adv,
    input  logic                          sync_pulse,
    input  logic [TW-1:0]                 sync_value,
    input  logic                          evt_error,
    input  logic                          evt_tick_rx,
    input  logic                          evt_pkt_start,
    input  logic                          cfg_wr,
    input  logic                          cfg_sel,
    input  logic [TW-1:0]                 cfg_wdata,
    input  logic                          ts_pop,
    output logic                          ts_valid,
    output logic [evt_ts_pkg::EV_TAG_W-1:0] ts_tag,
    output logic [TW-1:0]                 ts_time,
    output logic                          ts_overflow,
    output logic [TW-1:0]                 now_time,
    output logic                          trig_pending,
    output logic                          apply_stb,
    output logic [TW-1:0]                 param_out
);

    import evt_ts_pkg::*;

    logic [EV_COUNT-1:0] ev_req;
    logic [TW-1:0]       now;
    logic                wr_stage;
    logic                wr_trig;

    // Request vector in priority order, indexed by tag code.
    always_comb begin
        ev_req          = '0;
        ev_req[EV_ERR]  = evt_error;
        ev_req[EV_TICK] = evt_tick_rx;
        ev_req[EV_PKT]  = evt_pkt_start;
    end

    assign wr_stage = cfg_wr && !cfg_sel;
    assign wr_trig  = cfg_wr &&  cfg_sel;

    ts_time_base #(.TW(TW)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (time_adv),
        .sync_ld  (sync_pulse),
        .sync_val (sync_value),
        .now      (now)
    );

    ts_event_queue #(
        .TW    (TW),
        .DEPTH (DEPTH),
        .NSRC  (EV_COUNT),
        .TAGW  (EV_TAG_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_req     (ev_req),
        .stamp      (now),
        .pop        (ts_pop),
        .head_valid (ts_valid),
        .head_tag   (ts_tag),
        .head_time  (ts_time),
        .ovf        (ts_overflow)
    );

    ts_trigger_stage #(.TW(TW)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stage (wr_stage),
        .wr_trig  (wr_trig),
        .wdata    (cfg_wdata),
        .now      (now),
        .pending  (trig_pending),
        .apply    (apply_stb),
        .param    (param_out)
    );

    assign now_time = now;

endmodule

// File: rtl/evt_time_stamper_chk.sv
// Property checker for evt_time_stamper, attached with bind.
// Observes ports only.
module evt_time_stamper_chk #(
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          time_adv,
    input logic          sync_pulse,
    input logic [TW-1:0] sync_value,
    input logic          cfg_wr,
    input logic          cfg_sel,
    input logic          ts_overflow,
    input logic [TW-1:0] now_time,
    input logic          trig_pending,
    input logic          apply_stb,
    input logic [TW-1:0] param_out
);

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (time_adv && !sync_pulse) |=> (now_time == $past(now_time) + 1'b1)); // R2
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_adv && !sync_pulse) |=> $stable(now_time)); // R2
    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> (now_time == $past(sync_value))); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ts_overflow |=> ts_overflow); // R6
    AST_PARAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_stb |-> $stable(param_out)); // R7
    AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel) |=> trig_pending); // R8
    AST_APPLY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        apply_stb |=> !apply_stb); // R9
    AST_APPLY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        apply_stb |-> !trig_pending); // R9
    AST_APPLY_WAS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        apply_stb |-> $past(trig_pending)); // R9

endmodule

bind evt_time_stamper evt_time_stamper_chk #(.TW(TW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .time_adv     (time_adv),
    .sync_pulse   (sync_pulse),
    .sync_value   (sync_value),
    .cfg_wr       (cfg_wr),
    .cfg_sel      (cfg_sel),
    .ts_overflow  (ts_overflow),
    .now_time     (now_time),
    .trig_pending (trig_pending),
    .apply_stb    (apply_stb),
    .param_out    (param_out)
);

// File: tb/tb_evt_time_stamper.sv
`timescale 1ns/1ps
module tb_evt_time_stamper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        time_adv = 1'b0, sync_pulse = 1'b0;
    logic [31:0] sync_value = '0;
    logic        evt_error = 1'b0, evt_tick_rx = 1'b0, evt_pkt_start = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        ts_pop = 1'b0;
    logic        ts_valid, ts_overflow, trig_pending, apply_stb;
    logic [1:0]  ts_tag;
    logic [31:0] ts_time, now_time, param_out;

    int n_tot = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Reference model state, built from the requirements.
    logic [31:0] m_time, m_trig, m_stage, m_param;
    logic        m_pend, m_apply, m_ovf;
    logic [33:0] m_q [0:3];
    int          m_n;

    always #10 clk = ~clk;

    evt_time_stamper dut (
        .clk(clk), .rst_n(rst_n), .time_adv(time_adv), .sync_pulse(sync_pulse),
        .sync_value(sync_value), .evt_error(evt_error), .evt_tick_rx(evt_tick_rx),
        .evt_pkt_start(evt_pkt_start), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ts_pop(ts_pop), .ts_valid(ts_valid), .ts_tag(ts_tag),
        .ts_time(ts_time), .ts_overflow(ts_overflow), .now_time(now_time),
        .trig_pending(trig_pending), .apply_stb(apply_stb), .param_out(param_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model update at each edge, from the inputs held since the last negedge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = '0; m_trig = '0; m_stage = '0; m_param = '0;
            m_pend = 1'b0; m_apply = 1'b0; m_ovf = 1'b0; m_n = 0;
        end else begin
            logic fire;
            int   room;
            logic [2:0] evs;
            fire = m_pend && (m_time == m_trig) && !(cfg_wr && cfg_sel);
            m_apply = fire;
            if (fire) m_param = m_stage;
            if (cfg_wr && cfg_sel) begin m_trig = cfg_wdata; m_pend = 1'b1; end
            else if (fire) m_pend = 1'b0;
            if (cfg_wr && !cfg_sel) m_stage = cfg_wdata;
            room = 4 - m_n;
            if (ts_pop && m_n > 0) begin
                for (int k = 0; k < 3; k++) m_q[k] = m_q[k+1];
                m_n--;
            end
            evs = {evt_pkt_start, evt_tick_rx, evt_error};
            for (int k = 0; k < 3; k++) begin
                if (evs[k]) begin
                    if (room > 0) begin
                        m_q[m_n] = {k[1:0], m_time};
                        m_n++;
                        room--;
                    end else m_ovf = 1'b1;
                end
            end
            if (sync_pulse) m_time = sync_value;
            else if (time_adv) m_time = m_time + 32'd1;
        end
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R2 now_time", now_time, m_time);
            chk("R8 trig_pending", trig_pending, m_pend);
            chk("R9 apply_stb", apply_stb, m_apply);
            chk("R7 param_out", param_out, m_param);
            chk("R6 ts_valid", ts_valid, m_n != 0);
            chk("R6 ts_overflow", ts_overflow, m_ovf);
            if (m_n != 0) chk("R4 queue head", {ts_tag, ts_time}, m_q[0]);
        end
    end

    task automatic nx();
        @(negedge clk);
        sync_pulse = 0; evt_error = 0; evt_tick_rx = 0; evt_pkt_start = 0;
        cfg_wr = 0; ts_pop = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; nx(); nx(); rst_n = 1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tot++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin
        int seen;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        cmp_on = 1;
        // R1: reset state
        chk("R1 time", now_time, 0); chk("R1 pending", trig_pending, 0);
        chk("R1 apply", apply_stb, 0); chk("R1 param", param_out, 0);
        chk("R1 valid", ts_valid, 0); chk("R1 ovf", ts_overflow, 0);

        // R3 sync beats advance, R2 wrap
        time_adv = 1; sync_pulse = 1; sync_value = 32'hFFFF_FFFE; nx();
        chk("R3 sync load", now_time, 32'hFFFF_FFFE);
        nx(); chk("R2 step", now_time, 32'hFFFF_FFFF);
        nx(); chk("R2 wrap", now_time, 32'h0);
        time_adv = 0; nx(); chk("R2 hold", now_time, 32'h0);

        // R5 simultaneous events, R4 stamp value
        sync_pulse = 1; sync_value = 32'h100; nx();
        evt_pkt_start = 1; evt_tick_rx = 1; evt_error = 1; nx();
        chk("R5 first tag", ts_tag, 0); chk("R4 stamp", ts_time, 32'h100);
        ts_pop = 1; nx(); chk("R5 second tag", ts_tag, 1);
        ts_pop = 1; nx(); chk("R5 third tag", ts_tag, 2); chk("R4 stamp", ts_time, 32'h100);
        ts_pop = 1; nx(); chk("R6 empty after pops", ts_valid, 0);

        // R7/R8/R9 staged commit
        time_adv = 1; sync_pulse = 1; sync_value = 32'h200;
        cfg_wr = 1; cfg_sel = 0; cfg_wdata = 32'hCAFE_0001; nx();
        chk("R7 param unchanged by staging", param_out, 0);
        cfg_wr = 1; cfg_sel = 1; cfg_wdata = 32'h204; nx();
        chk("R8 armed", trig_pending, 1);
        nx(); nx(); nx(); chk("R9 no early apply", apply_stb, 0);
        nx(); chk("R9 apply", apply_stb, 1); chk("R9 param", param_out, 32'hCAFE_0001);
        chk("R9 disarmed", trig_pending, 0);
        nx(); chk("R9 single cycle", apply_stb, 0);

        // R10 trigger already passed
        cfg_wr = 1; cfg_sel = 1; cfg_wdata = 32'h100; nx();
        seen = 0;
        for (int k = 0; k < 30; k++) begin nx(); if (apply_stb) seen++; end
        chk("R10 no fire on passed time", seen, 0);
        chk("R10 still pending", trig_pending, 1);
        sync_pulse = 1; sync_value = 32'hFF; nx(); nx(); nx();
        chk("R10 fires on return", apply_stb, 1);

        // R11 rewrite in the matching cycle, then re-arm after fire
        time_adv = 0; sync_pulse = 1; sync_value = 32'h300; nx();
        cfg_wr = 1; cfg_sel = 1; cfg_wdata = 32'h300; nx();
        cfg_wr = 1; cfg_sel = 1; cfg_wdata = 32'h305; nx();
        chk("R11 rewrite wins", apply_stb, 0); chk("R11 pending", trig_pending, 1);
        time_adv = 1;
        for (int k = 0; k < 5; k++) nx();
        chk("R11 no fire yet", apply_stb, 0);
        nx(); chk("R11 fires at new time", apply_stb, 1);
        cfg_wr = 1; cfg_sel = 1; cfg_wdata = 32'h0; nx();
        chk("R11 re-armed after fire", trig_pending, 1);

        // R6 overflow: six events, four kept
        ts_pop = 1; nx();
        evt_error = 1; evt_tick_rx = 1; evt_pkt_start = 1; nx();
        evt_error = 1; evt_tick_rx = 1; evt_pkt_start = 1; nx();
        chk("R6 overflow set", ts_overflow, 1);
        chk("R6 oldest kept", ts_tag, 0);
        for (int k = 0; k < 4; k++) begin ts_pop = 1; nx(); end
        chk("R6 exactly four held", ts_valid, 0);

        // Random phase
        do_reset();
        for (int c = 0; c < 3000; c++) begin
            time_adv      = ($urandom % 4) != 0;
            sync_pulse    = ($urandom % 40) == 0;
            sync_value    = $urandom;
            evt_error     = ($urandom % 6) == 0;
            evt_tick_rx   = ($urandom % 5) == 0;
            evt_pkt_start = ($urandom % 4) == 0;
            ts_pop        = ($urandom % 2) == 0;
            cfg_wr        = ($urandom % 10) == 0;
            cfg_sel       = ($urandom % 2) == 0;
            cfg_wdata     = cfg_sel ? (m_time + ($urandom % 24)) : $urandom;
            nx();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule